// File: doc/BRIEF.md
# Register-Mapped Serial Port with Loopback

This block is an asynchronous serial transmitter and receiver placed behind a small register bus. Software sets the frame shape in a line register: word length 5 to 8 bits, one or two stop bits, and optional odd or even parity. The bit rate comes from a divisor register. The transmitter sends bytes from a transmit queue onto `tx_o`. The receiver rebuilds bytes from `rx_i` into a receive queue. A control register turns each direction on or off and can fold the transmit output back into the receiver for self-test. In loopback, the external receive pin is ignored.

When queueing is off, each direction keeps a single holding slot. When it is on, each direction has a `DEPTH`-entry FIFO with fill counts, full flags, reset strobes and trigger levels that drive two interrupt outputs. Errors are kept as sticky flags in an error register, and reading that register clears them.

The register bus has no back-pressure. A write strobe is taken in the cycle it is high. A read strobe returns data on `rdata` one cycle later. Reading the receive buffer pops it. Reading the error register clears the flags. Inside the block, both queues connect to their shifters through valid/ready pairs. A byte moves only in a cycle where both sides agree, so a full queue stalls the sender rather than losing data silently. The only drops are the two cases named below: a write to a full transmit queue, and a receive overrun.

Top module: `serial_port`

## Requirements
- R1: Register word addresses are 0 line, 1 control, 2 queue control, 3 divisor, 4 status, 5 error, 6 queue status, 7 transmit write, and 8 receive read. After reset all settings are zero, `tx_o` is high, status reads 0x6, queue status and error read 0, and both interrupts are low.
- R2: Line bits [1:0] = 00, 01, 10 or 11 select 5, 6, 7 or 8 data bits, sent least significant bit first. A received byte reads back with the unused upper bits at zero.
- R3: The sample tick fires once every divisor+1 clock cycles, and each serial bit lasts 16 ticks.
- R4: A frame is a low start bit, then the data bits, then the parity bit if enabled, then one high stop bit (two when line bit 2 is set). The line rests high between frames. Line bit 6 has no effect on the frame.
- R5: Line bits [5:3] = 100 select odd parity and 101 select even parity. Any other code sends no parity. On receive, a parity mismatch sets error bit 1.
- R6: When control bit 5 is set, the transmit output feeds the receiver and `rx_i` is ignored.
- R7: Control bits [3:2] set the transmit mode and [1:0] set the receive mode. A value of 00 stops that direction: no frame starts and no frame is received. A value of 01 runs it and enables its interrupt.
- R8: With queue-control bit 0 clear, each direction holds one byte. Status bit 0 means a received byte is waiting, and reading the receive buffer clears it. Status bit 1 means the transmit slot is empty. Status bit 2 means the transmitter is also idle. A write into an occupied transmit slot is dropped.
- R9: With queue-control bit 0 set, each queue holds `DEPTH` bytes in order. Queue status [5:0] gives the receive count, bit 6 receive full, [13:8] the transmit count, and bit 14 transmit full. A write to a full transmit queue is dropped.
- R10: A byte that arrives while the receive side is full is discarded and sets error bit 0. A read of the error register returns the flags and clears them.
- R11: A low level at the stop-bit sample sets error bit 2.
- R12: Writing queue-control bit 1 empties the receive queue, and bit 2 empties the transmit queue. Both bits read back as zero.
- R13: `rx_irq` is high in receive mode 01 when the receive count reaches 1, or in queue mode 1, 4, 8 or 12 for trigger code bits [5:4] = 00..11. `tx_irq` is high in transmit mode 01 when the transmit count is at most 0, or in queue mode 0, 4, 8 or 12 for bits [7:6].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after `rd_en` |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| tx_irq | output | 1 | Transmit level interrupt |
| rx_irq | output | 1 | Receive level interrupt |

## Verification
The bench builds the block with its default `DEPTH` of 16 and a 16-bit divisor, and sets the divisor to 0, 1 and 2 at run time. This keeps a whole frame within a few hundred cycles. With these values, filling the transmit queue to full, receiving a full receive queue followed by an overrun byte, and every trigger threshold can all be reached in a short run. Random word lengths, parities, stop counts and data are sent through loopback. Directed frames with wrong parity or a low stop bit are driven on `rx_i`.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int BUS_W = 16;
  localparam int AW    = 4;
  localparam int WORD_W = 8;

  localparam logic [AW-1:0] A_LINE  = 4'd0;
  localparam logic [AW-1:0] A_CTRL  = 4'd1;
  localparam logic [AW-1:0] A_FCTL  = 4'd2;
  localparam logic [AW-1:0] A_DIV   = 4'd3;
  localparam logic [AW-1:0] A_STAT  = 4'd4;
  localparam logic [AW-1:0] A_ERR   = 4'd5;
  localparam logic [AW-1:0] A_FSTAT = 4'd6;
  localparam logic [AW-1:0] A_TXH   = 4'd7;
  localparam logic [AW-1:0] A_RXB   = 4'd8;

  typedef enum logic [2:0] {PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP} phase_e;

  function automatic logic [WORD_W-1:0] len_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

  function automatic logic [4:0] rx_level(input logic [1:0] code);
    case (code)
      2'd0: return 5'd1;
      2'd1: return 5'd4;
      2'd2: return 5'd8;
      default: return 5'd12;
    endcase
  endfunction

  function automatic logic [4:0] tx_level(input logic [1:0] code);
    case (code)
      2'd0: return 5'd0;
      2'd1: return 5'd4;
      2'd2: return 5'd8;
      default: return 5'd12;
    endcase
  endfunction
endpackage

// File: rtl/sp_baud.sv
module sp_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sp_fifo.sv
module sp_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          single,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  input  logic          out_ready,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          push, pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign in_ready  = single ? (count == '0) : (count < CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rp];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sp_tx.sv
module sp_tx
  import sp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic [1:0]        len,
  input  logic              stop2,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              busy,
  output logic              txd
);
  phase_e            ph;
  logic [3:0]        cnt;
  logic [2:0]        bidx;
  logic [WORD_W-1:0] sh;
  logic              pbit, stop_seen;

  assign in_ready = (ph == PH_IDLE) && en;
  assign busy     = (ph != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; cnt <= '0; bidx <= '0; sh <= '0;
      pbit <= 1'b0; stop_seen <= 1'b0; txd <= 1'b1;
    end else if (ph == PH_IDLE) begin
      txd <= 1'b1;
      if (in_valid && in_ready) begin
        sh   <= in_data;
        pbit <= (^(in_data & len_mask(len))) ^ par_odd;
        ph   <= PH_START;
        txd  <= 1'b0;
        cnt  <= '0;
      end
    end else if (tick) begin
      if (cnt != 4'd15) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (ph)
          PH_START: begin
            ph <= PH_DATA; bidx <= '0; txd <= sh[0]; sh <= sh >> 1;
          end
          PH_DATA: begin
            if (bidx == 3'd4 + 3'(len)) begin
              stop_seen <= 1'b0;
              if (par_en) begin ph <= PH_PAR;  txd <= pbit; end
              else        begin ph <= PH_STOP; txd <= 1'b1; end
            end else begin
              bidx <= bidx + 1'b1; txd <= sh[0]; sh <= sh >> 1;
            end
          end
          PH_PAR: begin
            ph <= PH_STOP; txd <= 1'b1;
          end
          PH_STOP: begin
            if (stop2 && !stop_seen) stop_seen <= 1'b1;
            else                     ph <= PH_IDLE;
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import sp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              line,
  input  logic [1:0]        len,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              perr,
  output logic              ferr
);
  phase_e            ph;
  logic [3:0]        cnt;
  logic [2:0]        bidx;
  logic [WORD_W-1:0] sh;
  logic              prev, pbad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; cnt <= '0; bidx <= '0; sh <= '0; prev <= 1'b1; pbad <= 1'b0;
      out_valid <= 1'b0; out_data <= '0; perr <= 1'b0; ferr <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (tick) begin
        prev <= line;
        case (ph)
          PH_IDLE: begin
            if (en && prev && !line) begin
              ph <= PH_START; cnt <= '0; sh <= '0; pbad <= 1'b0;
            end
          end
          PH_START: begin
            if (cnt == 4'd7) begin
              cnt  <= '0;
              bidx <= '0;
              ph   <= line ? PH_IDLE : PH_DATA;
            end else cnt <= cnt + 1'b1;
          end
          PH_DATA: begin
            if (cnt == 4'd15) begin
              cnt      <= '0;
              sh[bidx] <= line;
              if (bidx == 3'd4 + 3'(len)) ph <= par_en ? PH_PAR : PH_STOP;
              else                        bidx <= bidx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          PH_PAR: begin
            if (cnt == 4'd15) begin
              cnt  <= '0;
              pbad <= ((^sh) ^ line) != par_odd;
              ph   <= PH_STOP;
            end else cnt <= cnt + 1'b1;
          end
          PH_STOP: begin
            if (cnt == 4'd15) begin
              cnt       <= '0;
              out_valid <= 1'b1;
              out_data  <= sh;
              perr      <= par_en && pbad;
              ferr      <= !line;
              ph        <= PH_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_port.sv
module serial_port
  import sp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  input  logic             rx_i,
  output logic             tx_o,
  output logic             tx_irq,
  output logic             rx_irq
);
  logic [6:0]       line_q;
  logic [5:0]       ctrl_q;
  logic             fen_q;
  logic [1:0]       rtrig_q, ttrig_q;
  logic [DIV_W-1:0] div_q;
  logic [2:0]       err_q, err_evt;
  logic [1:0]       rx_sync;

  logic [1:0] tx_mode, rx_mode;
  logic       loop_en, par_en, par_odd;
  assign tx_mode = ctrl_q[3:2];
  assign rx_mode = ctrl_q[1:0];
  assign loop_en = ctrl_q[5];
  assign par_en  = (line_q[5:4] == 2'b10);
  assign par_odd = ~line_q[3];

  logic wr_txh, rd_rxb, rd_err, wr_fctl, rx_clr, tx_clr;
  assign wr_txh  = wr_en && (addr == A_TXH);
  assign rd_rxb  = rd_en && (addr == A_RXB);
  assign rd_err  = rd_en && (addr == A_ERR);
  assign wr_fctl = wr_en && (addr == A_FCTL);
  assign rx_clr  = wr_fctl && wdata[1];
  assign tx_clr  = wr_fctl && wdata[2];

  logic baud_tick;
  sp_baud #(.DIV_W(DIV_W)) u_baud (.clk(clk), .rst_n(rst_n), .div(div_q), .tick(baud_tick));

  logic              txf_ready, txf_valid, tx_pop, tx_busy;
  logic [WORD_W-1:0] txf_data;
  logic [CW-1:0]     txf_cnt;

  sp_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .single(~fen_q),
    .in_valid(wr_txh), .in_data(wdata[WORD_W-1:0]), .in_ready(txf_ready),
    .out_valid(txf_valid), .out_data(txf_data), .out_ready(tx_pop), .count(txf_cnt)
  );

  sp_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(tx_mode != 2'b00),
    .len(line_q[1:0]), .stop2(line_q[2]), .par_en(par_en), .par_odd(par_odd),
    .in_valid(txf_valid), .in_data(txf_data), .in_ready(tx_pop),
    .busy(tx_busy), .txd(tx_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], loop_en ? tx_o : rx_i};
  end

  logic              rx_vld, rx_perr, rx_ferr;
  logic [WORD_W-1:0] rx_byte;

  sp_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(rx_mode != 2'b00),
    .line(rx_sync[1]), .len(line_q[1:0]), .par_en(par_en), .par_odd(par_odd),
    .out_valid(rx_vld), .out_data(rx_byte), .perr(rx_perr), .ferr(rx_ferr)
  );

  logic              rxf_ready, rxf_valid;
  logic [WORD_W-1:0] rxf_data;
  logic [CW-1:0]     rxf_cnt;

  sp_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .single(~fen_q),
    .in_valid(rx_vld), .in_data(rx_byte), .in_ready(rxf_ready),
    .out_valid(rxf_valid), .out_data(rxf_data), .out_ready(rd_rxb), .count(rxf_cnt)
  );

  assign err_evt = {rx_vld & rx_ferr, rx_vld & rx_perr, rx_vld & ~rxf_ready};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0; ctrl_q <= '0; fen_q <= 1'b0; rtrig_q <= '0; ttrig_q <= '0;
      div_q <= '0; err_q <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_LINE: line_q <= wdata[6:0];
          A_CTRL: ctrl_q <= wdata[5:0];
          A_FCTL: begin
            fen_q   <= wdata[0];
            rtrig_q <= wdata[5:4];
            ttrig_q <= wdata[7:6];
          end
          A_DIV:  div_q <= wdata[DIV_W-1:0];
          default: ;
        endcase
      end
      if (rd_err) err_q <= err_evt;
      else        err_q <= err_q | err_evt;
    end
  end

  logic txf_full, rxf_full, tx_all_idle;
  assign txf_full    = (txf_cnt == CW'(DEPTH));
  assign rxf_full    = (rxf_cnt == CW'(DEPTH));
  assign tx_all_idle = (txf_cnt == '0) && !tx_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        A_LINE:  rdata <= BUS_W'(line_q);
        A_CTRL:  rdata <= BUS_W'(ctrl_q);
        A_FCTL:  rdata <= BUS_W'({ttrig_q, rtrig_q, 3'b000, fen_q});
        A_DIV:   rdata <= BUS_W'(div_q);
        A_STAT:  rdata <= BUS_W'({tx_all_idle, txf_cnt == '0, rxf_cnt != '0});
        A_ERR:   rdata <= BUS_W'(err_q);
        A_FSTAT: rdata <= {1'b0, txf_full, 6'(txf_cnt), 1'b0, rxf_full, 6'(rxf_cnt)};
        A_RXB:   rdata <= rxf_valid ? BUS_W'(rxf_data) : '0;
        default: rdata <= '0;
      endcase
    end
  end

  logic [4:0] rx_lvl, tx_lvl;
  always_comb begin
    rx_lvl = fen_q ? rx_level(rtrig_q) : 5'd1;
    tx_lvl = fen_q ? tx_level(ttrig_q) : 5'd0;
    rx_irq = (rx_mode == 2'b01) && (int'(rxf_cnt) >= int'(rx_lvl));
    tx_irq = (tx_mode == 2'b01) && (int'(txf_cnt) <= int'(tx_lvl));
  end
endmodule

// File: rtl/serial_port_chk.sv
module serial_port_chk
  import sp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [AW-1:0]    addr,
  input logic             tick,
  input logic [DIV_W-1:0] div,
  input logic [CW-1:0]    tx_cnt,
  input logic             tx_room,
  input logic             tx_pop,
  input logic             tx_o,
  input logic             tx_busy,
  input logic [CW-1:0]    rx_cnt,
  input logic [2:0]       err,
  input logic [2:0]       err_evt
);
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick && div != '0 && !(wr_en && addr == A_DIV) |=> !tick); // R3

  AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_o); // R4

  AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == A_TXH && !tx_room && !tx_pop |=> tx_cnt == $past(tx_cnt)); // R9

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tx_cnt) <= DEPTH && int'(rx_cnt) <= DEPTH); // R9

  AST_ERR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == A_ERR && err_evt == 3'b000 |=> err == 3'b000); // R10
endmodule

bind serial_port serial_port_chk #(.DEPTH(DEPTH), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .tick(baud_tick), .div(div_q), .tx_cnt(txf_cnt), .tx_room(txf_ready),
  .tx_pop(tx_pop), .tx_o(tx_o), .tx_busy(tx_busy), .rx_cnt(rxf_cnt),
  .err(err_q), .err_evt(err_evt)
);

// File: tb/serial_port_test.sv
`timescale 1ns/1ps
module serial_port_test;
  import sp_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, rx_i = 1'b1;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic tx_o, tx_irq, rx_irq;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_port uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rx_i(rx_i), .tx_o(tx_o), .tx_irq(tx_irq), .rx_irq(rx_irq));

  function automatic logic [7:0] mask_of(input int len);
    return 8'((1 << (len + 5)) - 1);
  endfunction

  function automatic logic par_of(input logic [7:0] d, input int len, input bit odd);
    return (^(d & mask_of(len))) ^ odd;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wait_stat(input int b, input logic v);
    logic [15:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(A_STAT, s);
      if (s[b] == v) return;
    end
  endtask

  task automatic tx_settle();
    wait_stat(2, 1'b1);
    repeat (40) @(negedge clk);
  endtask

  // watch tx_o against a frame computed from the line setting
  task automatic ext_tx(input logic [15:0] lc, input logic [7:0] d, input int div);
    int len, per;
    bit pe, odd;
    len = int'(lc[1:0]); per = 16 * (div + 1);
    pe = (lc[5:4] == 2'b10); odd = !lc[3];
    wr(A_DIV, 16'(div)); wr(A_LINE, lc); wr(A_TXH, {8'h0, d});
    for (int i = 0; i < 400 && tx_o; i++) @(negedge clk);
    repeat (per / 2) @(negedge clk);
    check("R4 start bit", {15'h0, tx_o}, 16'h0);
    for (int k = 0; k < len + 5; k++) begin
      repeat (per) @(negedge clk);
      check("R2/R3 data bit", {15'h0, tx_o}, {15'h0, d[k]});
    end
    if (pe) begin
      repeat (per) @(negedge clk);
      check("R5 parity bit", {15'h0, tx_o}, {15'h0, par_of(d, len, odd)});
    end
    repeat (per) @(negedge clk);
    check("R4 stop bit", {15'h0, tx_o}, 16'h1);
    if (lc[2]) begin
      repeat (per) @(negedge clk);
      check("R4 second stop", {15'h0, tx_o}, 16'h1);
    end
    tx_settle();
  endtask

  // drive a frame on rx_i with a bit period of 32 cycles (divisor 1)
  task automatic ext_rx(input logic [15:0] lc, input logic [7:0] d, input bit bad_par, input bit bad_stop);
    int len;
    len = int'(lc[1:0]);
    @(negedge clk); rx_i = 1'b0; repeat (32) @(negedge clk);
    for (int k = 0; k < len + 5; k++) begin rx_i = d[k]; repeat (32) @(negedge clk); end
    if (lc[5:4] == 2'b10) begin
      rx_i = par_of(d, len, !lc[3]) ^ bad_par; repeat (32) @(negedge clk);
    end
    rx_i = !bad_stop; repeat (32) @(negedge clk);
    rx_i = 1'b1; repeat (64) @(negedge clk);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, lc;
    logic [7:0] d, q [17];
    int len, pm;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 tx idle", {15'h0, tx_o}, 16'h1);
    check("R1 irqs", {14'h0, tx_irq, rx_irq}, 16'h0);
    rd(A_STAT, v);  check("R1 status", v, 16'h6);
    rd(A_FSTAT, v); check("R1 queue status", v, 16'h0);
    rd(A_ERR, v);   check("R1 error", v, 16'h0);

    // R8 holding slot, R7 transmit off holds the line
    wr(A_DIV, 16'h0); wr(A_LINE, 16'h3); wr(A_CTRL, 16'h01);
    wr(A_TXH, 16'h5A); wr(A_TXH, 16'hC3);
    rd(A_STAT, v); check("R8 slot busy", v, 16'h0);
    repeat (100) @(negedge clk);
    check("R7 tx off keeps line", {15'h0, tx_o}, 16'h1);
    wr(A_CTRL, 16'h25); tx_settle();
    rd(A_STAT, v); check("R8 rx ready", v, 16'h7);
    rd(A_RXB, v);  check("R8 first byte kept", v, 16'h5A);
    rd(A_STAT, v); check("R8 second dropped, ready cleared", v, 16'h6);

    // R2 R4 R5 R6 random frames through loopback, rx_i held low
    rx_i = 1'b0;
    for (int i = 0; i < 24; i++) begin
      len = (i < 4) ? i : int'($urandom_range(0, 3));
      pm = int'($urandom_range(0, 2));
      lc = 16'(len) | (16'($urandom_range(0, 1)) << 2) | (16'($urandom_range(0, 1)) << 6);
      if (pm == 1) lc = lc | 16'h20;
      if (pm == 2) lc = lc | 16'h28;
      d = 8'($urandom);
      wr(A_LINE, lc); wr(A_TXH, {8'h0, d});
      wait_stat(0, 1'b1);
      rd(A_RXB, v); check("R2/R6 loopback byte", v, {8'h0, d & mask_of(len)});
      rd(A_ERR, v); check("R5 no false error", v, 16'h0);
      tx_settle();
    end
    rx_i = 1'b1;
    wr(A_LINE, 16'h3);

    // R7 receive off
    wr(A_CTRL, 16'h24); wr(A_TXH, 16'h11); tx_settle();
    rd(A_STAT, v); check("R7 rx off ignores frame", v, 16'h6);

    // R9 queue mode fill and drop
    wr(A_CTRL, 16'h01); wr(A_FCTL, 16'h01);
    for (int i = 0; i < 17; i++) begin q[i] = 8'($urandom); wr(A_TXH, {8'h0, q[i]}); end
    rd(A_FSTAT, v); check("R9 tx full", v, 16'h5000);
    wr(A_CTRL, 16'h25); tx_settle();
    rd(A_FSTAT, v); check("R9 rx full", v, 16'h0050);
    // R10 overrun
    wr(A_TXH, 16'hAA); tx_settle();
    rd(A_ERR, v); check("R10 overrun flag", v, 16'h1);
    rd(A_ERR, v); check("R10 read clears", v, 16'h0);
    for (int i = 0; i < 16; i++) begin
      rd(A_RXB, v); check("R9 order", v, {8'h0, q[i]});
    end
    rd(A_FSTAT, v); check("R9 drained", v, 16'h0);

    // R13 receive trigger 4
    wr(A_FCTL, 16'h11);
    check("R13 rx irq empty", {15'h0, rx_irq}, 16'h0);
    for (int i = 0; i < 3; i++) wr(A_TXH, 16'(i + 1));
    tx_settle();
    check("R13 rx irq below 4", {15'h0, rx_irq}, 16'h0);
    wr(A_TXH, 16'h44); tx_settle();
    check("R13 rx irq at 4", {15'h0, rx_irq}, 16'h1);
    // R12 receive reset strobe
    wr(A_FCTL, 16'h13);
    rd(A_FSTAT, v); check("R12 rx cleared", v, 16'h0);
    rd(A_FCTL, v);  check("R12 strobe reads zero", v, 16'h11);

    // R13 transmit trigger 0
    wr(A_FCTL, 16'h01);
    check("R13 tx irq empty", {15'h0, tx_irq}, 16'h1);
    for (int i = 0; i < 3; i++) wr(A_TXH, 16'(8'h70 + i));
    check("R13 tx irq pending", {15'h0, tx_irq}, 16'h0);
    tx_settle();
    check("R13 tx irq drained", {15'h0, tx_irq}, 16'h1);
    wr(A_FCTL, 16'h03);

    // R12 transmit reset strobe
    wr(A_CTRL, 16'h01);
    for (int i = 0; i < 5; i++) wr(A_TXH, 16'(i));
    rd(A_FSTAT, v); check("R12 tx count 5", v, 16'h0500);
    wr(A_FCTL, 16'h05);
    rd(A_FSTAT, v); check("R12 tx cleared", v, 16'h0);
    wr(A_FCTL, 16'h00);

    // R3 R4 R5 bit timing on tx_o
    wr(A_CTRL, 16'h05);
    ext_tx(16'h03, 8'hA5, 1);
    ext_tx(16'h2E, 8'h3C, 1);
    ext_tx(16'h68, 8'h1B, 2);

    // R5 R10 R11 frames on rx_i, divisor 1
    wr(A_DIV, 16'h1); wr(A_CTRL, 16'h05); wr(A_LINE, 16'h2B);
    ext_rx(16'h2B, 8'h96, 0, 0);
    rd(A_RXB, v); check("R6 external byte", v, 16'h96);
    rd(A_ERR, v); check("R5 good parity", v, 16'h0);
    ext_rx(16'h2B, 8'h35, 1, 0);
    rd(A_RXB, v); check("R5 bad parity byte", v, 16'h35);
    rd(A_ERR, v); check("R5 parity error", v, 16'h2);
    wr(A_LINE, 16'h02);
    ext_rx(16'h02, 8'h55, 0, 1);
    rd(A_RXB, v); check("R2 seven bit byte", v, 16'h55);
    rd(A_ERR, v); check("R11 framing error", v, 16'h4);
    rd(A_ERR, v); check("R10 cleared again", v, 16'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule